// File: doc/BRIEF.md
# High SMRAM Window Control Register with Address Remap

This block holds an 8-bit control register for a high system-management memory window and the address check and redirect logic that register governs. Software reads and writes the register through a small register bus (address, write strobe, write data, combinational read data). The register is decoded at offset 9Eh. Its top bit turns the high window on. Once the lock input has been seen, that bit can no longer be changed until reset. A sticky flag records an illegal access, and software clears it by writing a 1 to it.

Processor requests enter on a valid/ready stream with an address and an in-SMM qualifier. They leave on a downstream valid/ready stream carrying the DRAM address, with no register stage in between. When the window is active, a request into the 128 KiB high window FEDA0000h–FEDBFFFFh is redirected to the legacy window 000A0000h–000BFFFFh. All other addresses pass through unchanged. A request that violates protection is never forwarded. It is accepted at once, marked with a blocked strobe so that it can be dropped, and it sets the sticky flag.

Back-pressure rules: a forwarded request obeys the downstream ready, and `req_ready` follows `dn_ready`. A blocked request is always accepted in its own cycle, whatever `dn_ready` is. The remapped address is valid in the same cycle as `req_valid`.

Top module: `smram_hiwin_ctrl`

## Requirements
- R1: After reset, a read at offset 9Eh returns 38h and the `viol_flag` output is 0. A read at any other offset returns 00h.
- R2: Bit 7 (window enable) can be read and written at offset 9Eh while the lock has never been asserted. From the first cycle `smram_lock` is 1, writes to bit 7 are ignored until reset, even after the lock input falls again.
- R3: The high window is active only when `g_smram_en` is 1 and bit 7 is 1. Otherwise, window addresses pass through unchanged and are never blocked by the window check.
- R4: If the window is active, and a request address lies in FEDA0000h–FEDBFFFFh, and either `req_in_smm` or `smram_open` is 1, then `dn_addr` = 000A0000h OR address[16:0] in the same cycle.
- R5: Addresses outside FEDA0000h–FEDBFFFFh appear on `dn_addr` unchanged.
- R6: A valid request with `req_in_smm`=0 and `smram_open`=0 violates protection if it hits the active high window or the range `tseg_base` <= address < `tseg_limit`. In that cycle `req_blocked`=1, `dn_valid`=0 and `req_ready`=1, and on the next cycle bit 6 (`viol_flag`) reads 1.
- R7: Bit 6 is cleared only by a register write with data bit 6 = 1. A write with bit 6 = 0 leaves it unchanged. If a clear and a new violation fall in the same cycle, the flag stays 1.
- R8: Bits 5, 4 and 3 always read 1 and bits 2:0 always read 0. Writes to these bits are ignored.
- R9: For a request that is not blocked, `dn_valid` = `req_valid` and `req_ready` = `dn_ready`. `req_blocked` is 0 whenever `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register bus offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| g_smram_en | input | 1 | Global SMRAM enable |
| smram_open | input | 1 | Open control: SMRAM reachable outside SMM |
| smram_lock | input | 1 | Lock control for the enable bit |
| tseg_base | input | 32 | T-segment base (inclusive) |
| tseg_limit | input | 32 | T-segment limit (exclusive) |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Upstream request accepted |
| req_addr | input | 32 | Upstream request address |
| req_in_smm | input | 1 | Request issued in SMM |
| req_blocked | output | 1 | Request violates protection and is dropped |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream ready |
| dn_addr | output | 32 | Downstream (remapped) address |
| viol_flag | output | 1 | Sticky violation flag (bit 6) |

## Verification
The remap is driven with addresses at both window edges (FEDA0000h, FEDBFFFFh) and just outside them (FED9FFFFh, FEDC0000h), under each combination of global enable and bit 7. This separates an off-by-one window decode from a wrong enable gating. Violations are raised from a non-SMM window hit, from the T-segment base, and from the exclusive limit, which must not trip. SMM and open-control requests to the same addresses confirm that only unprivileged ones are blocked. The clear, the write of 0, and the clear colliding with a new violation tell set priority apart from plain W1C. Writes after a lock pulse has ended show whether the lock is latched.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 32;

  localparam int unsigned BIT_EN   = 7;
  localparam int unsigned BIT_VIOL = 6;

  localparam logic [REG_W-1:0] FIXED_ONES = 8'h38;

  typedef struct packed {
    logic hi_en;
    logic viol;
  } cfg_state_t;
endpackage

// File: rtl/smram_cfg_reg.sv
module smram_cfg_reg
  import smram_pkg::*;
#(
  parameter int unsigned          REG_AW     = 8,
  parameter logic [REG_AW-1:0]    REG_OFFSET = 8'h9E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              lock_in,
  input  logic              viol_set,
  output cfg_state_t        state
);
  cfg_state_t st_q, st_d;
  logic       lock_q;
  logic       hit;
  logic       en_wr_ok;

  assign hit      = (reg_addr == REG_OFFSET);
  assign en_wr_ok = !(lock_q || lock_in);

  always_comb begin
    st_d = st_q;
    if (reg_we && hit && en_wr_ok) st_d.hi_en = reg_wdata[BIT_EN];
    if (reg_we && hit && reg_wdata[BIT_VIOL]) st_d.viol = 1'b0;
    if (viol_set) st_d.viol = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      lock_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      lock_q <= lock_q | lock_in;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      reg_rdata           = FIXED_ONES;
      reg_rdata[BIT_EN]   = st_q.hi_en;
      reg_rdata[BIT_VIOL] = st_q.viol;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/smram_addr_map.sv
module smram_addr_map
  import smram_pkg::*;
#(
  parameter int unsigned        AW        = ADDR_W,
  parameter int unsigned        WIN_SHIFT = 17,
  parameter logic [AW-1:0]      HI_BASE   = 32'hFEDA0000,
  parameter logic [AW-1:0]      LO_BASE   = 32'h000A0000
) (
  input  logic          win_on,
  input  logic          open_i,
  input  logic [AW-1:0] tseg_base,
  input  logic [AW-1:0] tseg_limit,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_in_smm,
  output logic          req_ready,
  output logic          req_blocked,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [AW-1:0] dn_addr,
  output logic          viol_set
);
  localparam int unsigned TAG_W = AW - WIN_SHIFT;
  localparam logic [TAG_W-1:0] HI_TAG = HI_BASE[AW-1:WIN_SHIFT];
  localparam logic [TAG_W-1:0] LO_TAG = LO_BASE[AW-1:WIN_SHIFT];

  logic in_hi, in_tseg, privileged, bad;

  assign in_hi      = win_on && (req_addr[AW-1:WIN_SHIFT] == HI_TAG);
  assign in_tseg    = (req_addr >= tseg_base) && (req_addr < tseg_limit);
  assign privileged = req_in_smm || open_i;
  assign bad        = !privileged && (in_hi || in_tseg);

  assign req_blocked = req_valid && bad;
  assign viol_set    = req_blocked;
  assign dn_valid    = req_valid && !bad;
  assign req_ready   = bad ? 1'b1 : dn_ready;

  always_comb begin
    dn_addr = req_addr;
    if (in_hi && privileged) dn_addr = {LO_TAG, req_addr[WIN_SHIFT-1:0]};
  end
endmodule

// File: rtl/smram_hiwin_ctrl.sv
module smram_hiwin_ctrl
  import smram_pkg::*;
#(
  parameter logic [7:0] REG_OFFSET = 8'h9E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_we,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        g_smram_en,
  input  logic        smram_open,
  input  logic        smram_lock,
  input  logic [31:0] tseg_base,
  input  logic [31:0] tseg_limit,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic        req_in_smm,
  output logic        req_blocked,
  output logic        dn_valid,
  input  logic        dn_ready,
  output logic [31:0] dn_addr,
  output logic        viol_flag
);
  cfg_state_t cfg;
  logic       viol_set;
  logic       win_on;

  smram_cfg_reg #(.REG_AW(8), .REG_OFFSET(REG_OFFSET)) u_reg (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lock_in(smram_lock),
    .viol_set(viol_set), .state(cfg)
  );

  assign win_on = g_smram_en && cfg.hi_en;

  smram_addr_map #(.AW(32)) u_map (
    .win_on(win_on), .open_i(smram_open), .tseg_base(tseg_base),
    .tseg_limit(tseg_limit), .req_valid(req_valid), .req_addr(req_addr),
    .req_in_smm(req_in_smm), .req_ready(req_ready), .req_blocked(req_blocked),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
    .viol_set(viol_set)
  );

  assign viol_flag = cfg.viol;
endmodule

// File: rtl/smram_hiwin_chk.sv
module smram_hiwin_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  reg_addr,
  input logic        reg_we,
  input logic [7:0]  reg_wdata,
  input logic [7:0]  reg_rdata,
  input logic        g_smram_en,
  input logic        smram_lock,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_in_smm,
  input logic [31:0] req_addr,
  input logic        req_blocked,
  input logic        dn_valid,
  input logic        dn_ready,
  input logic [31:0] dn_addr,
  input logic        viol_flag
);
  logic en_bit, wr_clr;
  assign en_bit = reg_rdata[7];
  assign wr_clr = reg_we && (reg_addr == 8'h9E) && reg_wdata[6];

  p_fixed_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h9E) |-> (reg_rdata[5:0] == 6'b111000));

  p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smram_lock && reg_addr == 8'h9E) |=> (reg_addr != 8'h9E || $stable(en_bit)));

  p_viol_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_blocked |=> viol_flag);

  p_blocked_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_blocked |-> (!dn_valid && req_ready));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !wr_clr) |=> viol_flag);

  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_blocked) |-> (dn_valid == req_valid && req_ready == dn_ready));

  p_smm_remap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_in_smm && req_addr[31:17] == 15'h7F6D && reg_addr == 8'h9E
     && en_bit && g_smram_en) |-> (dn_addr == {15'h0005, req_addr[16:0]}));
endmodule

bind smram_hiwin_ctrl smram_hiwin_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .g_smram_en(g_smram_en),
  .smram_lock(smram_lock), .req_valid(req_valid), .req_ready(req_ready),
  .req_in_smm(req_in_smm), .req_addr(req_addr), .req_blocked(req_blocked),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr),
  .viol_flag(viol_flag)
);

// File: tb/sim_smram_hiwin_ctrl.sv
`timescale 1ns/1ps
module sim_smram_hiwin_ctrl;
  logic clk = 0, rst_n = 0;
  logic [7:0] reg_addr = 8'h9E, reg_wdata = 0, reg_rdata;
  logic reg_we = 0, g_smram_en = 0, smram_open = 0, smram_lock = 0;
  logic [31:0] tseg_base = 32'h1000_0000, tseg_limit = 32'h1010_0000;
  logic req_valid = 0, req_in_smm = 0, dn_ready = 1;
  logic [31:0] req_addr = 0, dn_addr;
  logic req_ready, req_blocked, dn_valid, viol_flag;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  smram_hiwin_ctrl u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic req(logic [31:0] a, logic smm);
    req_valid = 1; req_addr = a; req_in_smm = smm; #1;
  endtask

  task automatic idle();
    req_valid = 0; req_in_smm = 0; #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset(); reg_addr = 8'h9E; #1;
    chk("R1 reset value", reg_rdata, 8'h38);
    chk("R1 flag clear", viol_flag, 0);
    reg_addr = 8'h9F; #1;
    chk("R1 other offset", reg_rdata, 0);
    reg_addr = 8'h9E;
  endtask

  task automatic t_rw();
    wr(8'hFF); chk("R2 R8 write all ones", reg_rdata, 8'hB8);
    wr(8'h07); chk("R8 low bits ignored", reg_rdata, 8'h38);
    wr(8'h80); chk("R2 enable set", reg_rdata, 8'hB8);
  endtask

  task automatic t_window();
    g_smram_en = 0; req(32'hFEDA1234, 1);
    chk("R3 global off passthru", dn_addr, 32'hFEDA1234);
    g_smram_en = 1; req(32'hFEDA1234, 1);
    chk("R4 remap", dn_addr, 32'h000A1234);
    req(32'hFEDBFFFF, 1); chk("R4 top edge", dn_addr, 32'h000BFFFF);
    req(32'hFEDA0000, 1); chk("R4 low edge", dn_addr, 32'h000A0000);
    req(32'hFEDC0000, 1); chk("R5 above window", dn_addr, 32'hFEDC0000);
    req(32'hFED9FFFF, 1); chk("R5 below window", dn_addr, 32'hFED9FFFF);
    smram_open = 1; req(32'hFEDA0044, 0);
    chk("R4 open remap", dn_addr, 32'h000A0044);
    chk("R6 open not blocked", req_blocked, 0);
    smram_open = 0;
    wr(8'h00); req(32'hFEDA0044, 0);
    chk("R3 bit7 off no block", req_blocked, 0);
    chk("R3 bit7 off passthru", dn_addr, 32'hFEDA0044);
    idle(); wr(8'h80);
  endtask

  task automatic t_viol();
    @(negedge clk); req(32'hFEDA0010, 0);
    chk("R6 blocked", req_blocked, 1);
    chk("R6 not forwarded", dn_valid, 0);
    dn_ready = 0; #1; chk("R6 ready while blocked", req_ready, 1); dn_ready = 1;
    @(negedge clk); idle();
    chk("R6 flag set", viol_flag, 1);
    chk("R6 bit6 read", reg_rdata, 8'hF8);
    wr(8'h80); chk("R7 write0 keeps", viol_flag, 1);
    wr(8'hC0); chk("R7 w1c clears", viol_flag, 0);
    req(32'h1010_0000, 0); chk("R6 limit exclusive", req_blocked, 0);
    req(32'h1000_0000, 0); chk("R6 tseg base blocks", req_blocked, 1);
    req(32'h1000_0000, 1); chk("R6 smm tseg ok", req_blocked, 0);
    idle();
    @(negedge clk); reg_we = 1; reg_wdata = 8'hC0; req(32'h1000_0004, 0);
    @(negedge clk); reg_we = 0; idle();
    chk("R7 set wins", viol_flag, 1);
    wr(8'hC0); chk("R7 cleared again", viol_flag, 0);
  endtask

  task automatic t_stream();
    dn_ready = 0; req(32'h2000_0000, 0);
    chk("R9 ready follows", req_ready, 0);
    chk("R9 valid passes", dn_valid, 1);
    dn_ready = 1; #1; chk("R9 ready high", req_ready, 1);
    idle(); chk("R9 no blocked idle", req_blocked, 0);
  endtask

  task automatic t_lock();
    @(negedge clk); smram_lock = 1; reg_we = 1; reg_wdata = 8'h00;
    @(negedge clk); reg_we = 0; smram_lock = 0;
    chk("R2 lock blocks write", reg_rdata[7], 1);
    wr(8'h00); chk("R2 lock sticky", reg_rdata[7], 1);
    do_reset(); #1; chk("R2 R1 reset unlocks", reg_rdata, 8'h38);
    wr(8'h80); chk("R2 writable after reset", reg_rdata[7], 1);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_rw(); t_window(); t_viol(); t_stream(); t_lock();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule